// File: doc/BRIEF.md
# Packed Byte Shuffle Unit

This block rearranges the bytes of a 128-bit or 256-bit vector. The rearrangement is set by a second vector that holds one index byte for each output byte. An index byte can do one of two things. It can force its output byte to zero, or it can name the source byte to copy into that position. It names that byte with a small select field that counts only within the byte's own 128-bit half. The result is registered and appears one clock after the operation is presented, together with an output valid.

The caller picks the vector width and chooses between two destination conventions:

- **Legacy mode.** The caller feeds the old destination value as the data vector. The unit shuffles it as a whole snapshot. The upper 128 bits of the destination pass through unchanged.
- **Three-operand mode.** The data comes from a separate source. The upper 128 bits are zeroed when a 128-bit operation is run.

Top module: `pbs_shuffle`

## Requirements
- R1: Output byte i (bits 8i+7:8i) is controlled only by index byte i (same bit positions of `idx_data`).
- R2: When bit 7 of an index byte is 1, the matching output byte is 0x00 whatever the other index bits hold.
- R3: When bit 7 is 0, bits 3:0 of index byte i give k, and output byte i equals byte k of the 16-byte half that contains lane i.
- R4: Bits 6:4 of every index byte have no effect on the output.
- R5: With `wide_sel`=0 and `legacy_mode`=0, output bits 255:128 are 0, and `src_data[255:128]` has no effect.
- R6: With `wide_sel`=0 and `legacy_mode`=1, output bits 255:128 equal `dest_upper` as presented with the operation.
- R7: With `wide_sel`=1, each half shuffles on its own. An upper-half lane with select k takes source byte 16+k. `legacy_mode` and `dest_upper` have no effect.
- R8: While `rst_n` is low, `out_data` is 0 and `out_valid` is 0.
- R9: Every lane reads the data vector as presented, never a partially written result. For example, selecting byte i-1 into lane i gives a plain rotation by one byte.
- R10: `out_valid` equals `in_valid` sampled at the previous rising edge. `out_data` loads only on edges where `in_valid` is 1 and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Operation presented this cycle |
| wide_sel | input | 1 | 1: 256-bit shuffle, 0: 128-bit shuffle |
| legacy_mode | input | 1 | 1: keep destination upper bits in 128-bit form, 0: zero them |
| src_data | input | 256 | Data vector to shuffle |
| idx_data | input | 256 | One index byte per output byte |
| dest_upper | input | 128 | Current upper 128 bits of the destination |
| out_data | output | 256 | Shuffled result |
| out_valid | output | 1 | Result valid, one cycle after in_valid |

## Verification
Two functions can act on the same output byte in the same cycle:

- **Zeroing and selecting.** An index byte with the clear bit set can also carry a select field and nonzero ignored bits. The bench builds such bytes and requires a zero byte, not the selected one.
- **Upper-half source and upper-half result.** In 128-bit mode, the upper source half holds live data while the upper result comes from `dest_upper` or from zero. Directed cases fill both with distinct patterns. Every byte is then compared against the bench's own model.

// File: rtl/pbs_pkg.sv
package pbs_pkg;
  localparam int BYTE_W    = 8;
  localparam int CLEAR_BIT = 7;   // index byte bit that forces a zero byte
endpackage

// File: rtl/pbs_byte_pick.sv
module pbs_byte_pick
  import pbs_pkg::*;
#(
  parameter int LANE_BYTES = 16
) (
  input  logic [LANE_BYTES*BYTE_W-1:0] half_src,
  input  logic [BYTE_W-1:0]            idx_byte,
  output logic [BYTE_W-1:0]            pick
);
  localparam int SEL_W = $clog2(LANE_BYTES);

  logic [SEL_W-1:0] sel;
  logic             ignored_unused;

  assign sel            = idx_byte[SEL_W-1:0];
  assign ignored_unused = ^idx_byte[CLEAR_BIT-1:SEL_W];

  always_comb begin
    pick = '0;
    if (!idx_byte[CLEAR_BIT]) begin
      pick = half_src[sel*BYTE_W +: BYTE_W];
    end
  end
endmodule

// File: rtl/pbs_half_shuffle.sv
module pbs_half_shuffle
  import pbs_pkg::*;
#(
  parameter int LANE_BYTES = 16
) (
  input  logic [LANE_BYTES*BYTE_W-1:0] half_src,
  input  logic [LANE_BYTES*BYTE_W-1:0] half_idx,
  output logic [LANE_BYTES*BYTE_W-1:0] half_out
);
  for (genvar b = 0; b < LANE_BYTES; b++) begin : g_lane
    pbs_byte_pick #(.LANE_BYTES(LANE_BYTES)) u_pick (
      .half_src (half_src),
      .idx_byte (half_idx[b*BYTE_W +: BYTE_W]),
      .pick     (half_out[b*BYTE_W +: BYTE_W])
    );
  end
endmodule

// File: rtl/pbs_shuffle.sv
module pbs_shuffle
  import pbs_pkg::*;
#(
  parameter int LANE_BYTES = 16,
  parameter int NUM_HALVES = 2
) (
  input  logic                                       clk,
  input  logic                                       rst_n,
  input  logic                                       in_valid,
  input  logic                                       wide_sel,
  input  logic                                       legacy_mode,
  input  logic [LANE_BYTES*NUM_HALVES*BYTE_W-1:0]    src_data,
  input  logic [LANE_BYTES*NUM_HALVES*BYTE_W-1:0]    idx_data,
  input  logic [LANE_BYTES*(NUM_HALVES-1)*BYTE_W-1:0] dest_upper,
  output logic [LANE_BYTES*NUM_HALVES*BYTE_W-1:0]    out_data,
  output logic                                       out_valid
);
  localparam int HALF_W = LANE_BYTES * BYTE_W;
  localparam int VEC_W  = HALF_W * NUM_HALVES;
  localparam int UP_W   = VEC_W - HALF_W;

  logic [VEC_W-1:0] shuf_all;
  logic [UP_W-1:0]  upper_sel;
  logic [VEC_W-1:0] data_d;
  logic             valid_d;

  // each half shuffles from its own 16 source bytes only (R3, R7)
  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
    pbs_half_shuffle #(.LANE_BYTES(LANE_BYTES)) u_half (
      .half_src (src_data[h*HALF_W +: HALF_W]),
      .half_idx (idx_data[h*HALF_W +: HALF_W]),
      .half_out (shuf_all[h*HALF_W +: HALF_W])
    );
  end

  // upper-half policy (R5, R6, R7)
  always_comb begin
    if (wide_sel)         upper_sel = shuf_all[VEC_W-1:HALF_W];
    else if (legacy_mode) upper_sel = dest_upper;
    else                  upper_sel = '0;
  end

  // next state with explicit load enable (R10)
  always_comb begin
    valid_d = in_valid;
    data_d  = out_data;
    if (in_valid) data_d = {upper_sel, shuf_all[HALF_W-1:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_data  <= '0;
      out_valid <= 1'b0;
    end else begin
      out_data  <= data_d;
      out_valid <= valid_d;
    end
  end

  p_valid_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_valid_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_data));
  p_clear_lane0_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && idx_data[CLEAR_BIT]) |=> (out_data[BYTE_W-1:0] == '0));
  p_upper_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !wide_sel && !legacy_mode) |=> (out_data[VEC_W-1:HALF_W] == '0));
  p_upper_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !wide_sel && legacy_mode) |=> (out_data[VEC_W-1:HALF_W] == $past(dest_upper)));
endmodule

// File: tb/pbs_shuffle_bench.sv
`timescale 1ns/1ps
module pbs_shuffle_bench;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid, wide_sel, legacy_mode;
  logic [255:0] src_data, idx_data, out_data;
  logic [127:0] dest_upper;
  logic         out_valid;
  int           errors = 0;
  int           checks = 0;

  always #4 clk = ~clk;   // 125 MHz

  pbs_shuffle u_pbs_shuffle (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .wide_sel(wide_sel),
    .legacy_mode(legacy_mode), .src_data(src_data), .idx_data(idx_data),
    .dest_upper(dest_upper), .out_data(out_data), .out_valid(out_valid)
  );

  function automatic logic [255:0] model(input logic [255:0] s, input logic [255:0] x,
                                         input logic w, input logic leg,
                                         input logic [127:0] up);
    logic [255:0] r;
    r = '0;
    for (int i = 0; i < 32; i++) begin
      int base;
      int k;
      base = (i >= 16) ? 16 : 0;
      k    = int'(x[i*8 +: 4]);
      if (!x[i*8+7]) r[i*8 +: 8] = s[(base+k)*8 +: 8];
    end
    if (!w) r[255:128] = leg ? up : 128'd0;
    return r;
  endfunction

  function automatic logic [255:0] rnd256();
    logic [255:0] v;
    for (int i = 0; i < 8; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one operation: drive at negedge, result visible after next posedge
  task automatic run_op(input logic [255:0] s, input logic [255:0] x, input logic w,
                        input logic leg, input logic [127:0] up);
    @(negedge clk);
    src_data = s; idx_data = x; wide_sel = w; legacy_mode = leg; dest_upper = up;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic op_and_check(input string req, input logic [255:0] s, input logic [255:0] x,
                              input logic w, input logic leg, input logic [127:0] up);
    run_op(s, x, w, leg, up);
    check(req, out_data, model(s, x, w, leg, up));
    check({req, " valid"}, {255'd0, out_valid}, 256'd1);
  endtask

  task automatic t_reset();
    check("R8 data", out_data, '0);
    check("R8 valid", {255'd0, out_valid}, '0);
  endtask

  task automatic t_rotate();   // R9, R1, R3
    logic [255:0] s, x;
    s = rnd256();
    for (int i = 0; i < 16; i++) x[i*8 +: 8] = 8'((i + 15) % 16);
    x[255:128] = '0;
    run_op(s, x, 1'b0, 1'b0, '1);
    check("R9 rotate", out_data[127:0], {s[119:0], s[127:120]});
    check("R5 upper zero", out_data[255:128], '0);
  endtask

  task automatic t_all_clear();   // R2
    logic [255:0] x;
    for (int i = 0; i < 32; i++) x[i*8 +: 8] = 8'h80 | 8'($urandom % 128);
    op_and_check("R2 all clear", rnd256(), x, 1'b1, 1'b0, '0);
    check("R2 zero", out_data, '0);
  endtask

  task automatic t_ignored_bits();   // R4
    logic [255:0] s, x, xn;
    logic [255:0] first;
    s = rnd256();
    for (int i = 0; i < 32; i++) begin
      x[i*8 +: 8]  = {1'b0, 3'b000, 4'($urandom)};
      xn[i*8 +: 8] = x[i*8 +: 8] | {1'b0, 3'($urandom | 1), 4'b0};
    end
    run_op(s, x, 1'b1, 1'b0, '0);
    first = out_data;
    run_op(s, xn, 1'b1, 1'b0, '0);
    check("R4 ignored bits", out_data, first);
    check("R4 model", out_data, model(s, x, 1'b1, 1'b0, '0));
  endtask

  task automatic t_legacy();   // R6, R5
    logic [255:0] s, x;
    logic [127:0] up;
    s = rnd256(); x = rnd256(); up = rnd256();
    op_and_check("R6 legacy keep", s, x, 1'b0, 1'b1, up);
    check("R6 upper", out_data[255:128], up);
    op_and_check("R5 three-operand", s, x, 1'b0, 1'b0, up);
  endtask

  task automatic t_wide();   // R7
    logic [255:0] s, x;
    s = rnd256();
    x = '0;   // every lane selects byte 0 of its half
    run_op(s, x, 1'b1, 1'b1, '1);
    check("R7 upper half", out_data[255:128], {16{s[135:128]}});
    check("R7 lower half", out_data[127:0], {16{s[7:0]}});
  endtask

  task automatic t_hold();   // R10
    logic [255:0] held;
    run_op(rnd256(), rnd256(), 1'b1, 1'b0, '0);
    held = out_data;
    @(negedge clk);
    src_data = rnd256(); idx_data = rnd256();
    @(negedge clk);
    check("R10 hold data", out_data, held);
    check("R10 valid low", {255'd0, out_valid}, '0);
  endtask

  task automatic t_random();   // R1, R3
    for (int n = 0; n < 40; n++) begin
      op_and_check("R1 R3 random", rnd256(), rnd256(), 1'($urandom), 1'($urandom), rnd256());
    end
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; wide_sel = 1'b0; legacy_mode = 1'b0;
    src_data = '0; idx_data = '0; dest_upper = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_rotate();
    t_all_clear();
    t_ignored_bits();
    t_legacy();
    t_wide();
    t_hold();
    t_random();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule